// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit register-to-register datapath. Each cycle it may accept one operation: a 4-bit opcode, the first source operand, a second operand that an upstream shifter has already shifted, and the shifter's carry-out. It also takes the current condition flags and a set-flags request. One clock later it presents a registered result, a write enable for the destination register, and the next value of the four condition flags (negative, zero, carry, overflow).

The operations are addition and subtraction, each with or without the carry flag. There are reverse subtractions that take the first operand away from the second. There are bitwise AND, XOR, OR and bit-clear, and moves of the second operand or of its complement. Two compares update the flags and never write a register. For subtractions the carry flag works as an inverted borrow. Flags change only when set-flags is asserted, except for compares, which always set them. The two opcode values with no operation assigned (8 and 9) write nothing and leave the flags as they are.

The operand width is a parameter (`W`, default 32). The flag bus is packed as {N, Z, C, V}, from bit 3 down to bit 0.

Top module: `dp_alu_core`

## Requirements
- R1: While rst_n is low, and after reset until the first accepted operation, res_valid, result_we, result and flags_out are all zero.
- R2: An operation presented with op_valid high shows its outputs on the next clock edge, with res_valid high. A cycle with op_valid low drives res_valid and result_we low on the next edge and keeps result and flags_out unchanged.
- R3: Opcode 4 (add) gives rn+op2. Opcode 5 (add with carry) gives rn+op2+C, where C is flags_in bit 1. Both are taken modulo 2^W.
- R4: Opcode 2 (subtract) gives rn-op2. Opcode 6 (subtract with carry) gives rn-op2-(1-C).
- R5: Opcode 3 (reverse subtract) gives op2-rn. Opcode 7 (reverse subtract with carry) gives op2-rn-(1-C).
- R6: Opcode 0 gives rn AND op2. Opcode 1 gives rn XOR op2. Opcode 12 gives rn OR op2. Opcode 14 gives rn AND NOT op2.
- R7: Opcode 13 writes op2 and opcode 15 writes NOT op2. The value of rn has no effect on either.
- R8: Opcode 10 (compare) and opcode 11 (compare negative) never assert result_we. They always update the flags, as for rn-op2 and rn+op2 respectively, whatever set_flags is.
- R9: An opcode that is not a compare, presented with set_flags low, gives flags_out equal to flags_in.
- R10: When the flags are updated, N equals bit W-1 of the computed value and Z is 1 exactly when all W bits of it are zero.
- R11: For the arithmetic opcodes (2-7, 10, 11), an updated C is the carry out of the adder, which is 1 when a subtraction needs no borrow. An updated V is 1 on two's-complement overflow.
- R12: For the logical and move opcodes (0, 1, 12-15), an updated C takes shift_carry and V keeps the value of flags_in bit 0.
- R13: Opcodes 8 and 9 never assert result_we and give flags_out equal to flags_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag update |
| rn | input | W | First source operand |
| op2 | input | W | Second operand, already shifted |
| shift_carry | input | 1 | Carry out of the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| res_valid | output | 1 | Outputs belong to an accepted operation |
| result | output | W | Computed value |
| result_we | output | 1 | Destination register write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench uses a 4-bit instance and sweeps every opcode against every operand pair, both carry values and both set-flags values. It computes the expected flags from signed and unsigned integer arithmetic. That sweep reaches the carry and overflow edges directly:

- A design that did not invert the borrow would get C wrong for every subtraction.
- A design that used the wrong operand sign when checking overflow would set V wrongly on the reverse subtractions.
- A design that let compares write would raise result_we for opcodes 10 and 11.

The bench also drives varying values of rn under the move opcodes, to expose any leak of the first operand. Idle cycles check that the result and the flags hold their values.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_EOR = 4'd1,
        OP_SUB = 4'd2,
        OP_RSB = 4'd3,
        OP_ADD = 4'd4,
        OP_ADC = 4'd5,
        OP_SBC = 4'd6,
        OP_RSC = 4'd7,
        OP_NA8 = 4'd8,
        OP_NA9 = 4'd9,
        OP_CMP = 4'd10,
        OP_CMN = 4'd11,
        OP_ORR = 4'd12,
        OP_MOV = 4'd13,
        OP_BIC = 4'd14,
        OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_LOGIC,
        CLS_ARITH,
        CLS_TEST,
        CLS_NONE
    } alu_cls_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic alu_cls_e op_class(input alu_op_e op);
        alu_cls_e cls;
        unique case (op)
            OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN: cls = CLS_LOGIC;
            OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC: cls = CLS_ARITH;
            OP_CMP, OP_CMN:                                 cls = CLS_TEST;
            OP_NA8, OP_NA9:                                 cls = CLS_NONE;
        endcase
        return cls;
    endfunction

endpackage

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   rn,
    input  logic [W-1:0]   op2,
    input  logic           c_flag,
    output logic [W-1:0]   sum,
    output logic           c_out,
    output logic           v_out
);
    localparam int MSB = W - 1;

    logic [W-1:0] xa;
    logic [W-1:0] yb;
    logic         ci;
    logic [W:0]   sum_ext;

    // Steer both operands and the carry-in so that one adder serves every form
    always_comb begin
        unique case (op)
            OP_ADD, OP_CMN: begin xa = rn;  yb = op2;  ci = 1'b0;   end
            OP_ADC:         begin xa = rn;  yb = op2;  ci = c_flag; end
            OP_SUB, OP_CMP: begin xa = rn;  yb = ~op2; ci = 1'b1;   end
            OP_SBC:         begin xa = rn;  yb = ~op2; ci = c_flag; end
            OP_RSB:         begin xa = op2; yb = ~rn;  ci = 1'b1;   end
            OP_RSC:         begin xa = op2; yb = ~rn;  ci = c_flag; end
            default:        begin xa = rn;  yb = op2;  ci = 1'b0;   end
        endcase
    end

    always_comb begin
        sum_ext = {1'b0, xa} + {1'b0, yb} + {{W{1'b0}}, ci};
        sum     = sum_ext[W-1:0];
        c_out   = sum_ext[W];
        v_out   = (xa[MSB] == yb[MSB]) && (sum_ext[MSB] != xa[MSB]);
    end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   rn,
    input  logic [W-1:0]   op2,
    output logic [W-1:0]   res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = rn & op2;
            OP_EOR:  res = rn ^ op2;
            OP_ORR:  res = rn | op2;
            OP_BIC:  res = rn & ~op2;
            OP_MOV:  res = op2;
            OP_MVN:  res = ~op2;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_cls_e       cls,
    input  logic           set_flags,
    input  logic [W-1:0]   arith_res,
    input  logic           arith_c,
    input  logic           arith_v,
    input  logic [W-1:0]   logic_res,
    input  logic           shift_carry,
    input  alu_flags_t     flags_in,
    output logic [W-1:0]   value,
    output logic           write_en,
    output alu_flags_t     flags_nxt
);
    localparam int MSB = W - 1;

    logic update;

    always_comb begin
        unique case (cls)
            CLS_LOGIC: begin value = logic_res; write_en = 1'b1; update = set_flags; end
            CLS_ARITH: begin value = arith_res; write_en = 1'b1; update = set_flags; end
            CLS_TEST:  begin value = arith_res; write_en = 1'b0; update = 1'b1;      end
            CLS_NONE:  begin value = '0;        write_en = 1'b0; update = 1'b0;      end
        endcase
    end

    always_comb begin
        flags_nxt = flags_in;
        if (update) begin
            flags_nxt.n = value[MSB];
            flags_nxt.z = (value == '0);
            if (cls == CLS_LOGIC) begin
                flags_nxt.c = shift_carry;
            end else begin
                flags_nxt.c = arith_c;
                flags_nxt.v = arith_v;
            end
        end
    end

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [3:0]     opcode,
    input  logic           set_flags,
    input  logic [W-1:0]   rn,
    input  logic [W-1:0]   op2,
    input  logic           shift_carry,
    input  logic [3:0]     flags_in,
    output logic           res_valid,
    output logic [W-1:0]   result,
    output logic           result_we,
    output logic [3:0]     flags_out
);
    alu_op_e    op;
    alu_cls_e   cls;
    alu_flags_t f_in;
    alu_flags_t f_nxt;
    logic [W-1:0] a_res;
    logic [W-1:0] l_res;
    logic [W-1:0] value;
    logic         a_c;
    logic         a_v;
    logic         we_nxt;

    assign op   = alu_op_e'(opcode);
    assign cls  = op_class(op);
    assign f_in = alu_flags_t'(flags_in);

    dp_alu_arith #(.W(W)) u_arith (
        .op     (op),
        .rn     (rn),
        .op2    (op2),
        .c_flag (f_in.c),
        .sum    (a_res),
        .c_out  (a_c),
        .v_out  (a_v)
    );

    dp_alu_logic #(.W(W)) u_logic (
        .op  (op),
        .rn  (rn),
        .op2 (op2),
        .res (l_res)
    );

    dp_alu_flags #(.W(W)) u_flags (
        .cls         (cls),
        .set_flags   (set_flags),
        .arith_res   (a_res),
        .arith_c     (a_c),
        .arith_v     (a_v),
        .logic_res   (l_res),
        .shift_carry (shift_carry),
        .flags_in    (f_in),
        .value       (value),
        .write_en    (we_nxt),
        .flags_nxt   (f_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result_we <= 1'b0;
            result    <= '0;
            flags_out <= '0;
        end else if (op_valid) begin
            res_valid <= 1'b1;
            result_we <= we_nxt;
            result    <= value;
            flags_out <= f_nxt;
        end else begin
            res_valid <= 1'b0;
            result_we <= 1'b0;
        end
    end

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   opcode,
    input logic         set_flags,
    input logic [W-1:0] rn,
    input logic [W-1:0] op2,
    input logic         shift_carry,
    input logic [3:0]   flags_in,
    input logic         res_valid,
    input logic [W-1:0] result,
    input logic         result_we,
    input logic [3:0]   flags_out
);
    logic is_test;
    logic is_logic;
    logic is_none;

    assign is_test  = (opcode == 4'd10) || (opcode == 4'd11);
    assign is_none  = (opcode == 4'd8) || (opcode == 4'd9);
    assign is_logic = (opcode == 4'd0) || (opcode == 4'd1) || (opcode >= 4'd12);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid && !result_we && $stable(result) && $stable(flags_out));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    p_mov_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && opcode == 4'd13 |=> result == $past(op2) && result_we);

    p_test_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && is_test |=> !result_we);

    p_flag_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !set_flags && !is_test |=> flags_out == $past(flags_in));

    p_nz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && set_flags && !is_none |=>
            flags_out[3] == result[W-1] && flags_out[2] == (result == '0));

    p_logic_cv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && set_flags && is_logic |=>
            flags_out[1] == $past(shift_carry) && flags_out[0] == $past(flags_in[0]));

    p_unused_r13: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && is_none |=> !result_we && flags_out == $past(flags_in));

endmodule

bind dp_alu_core dp_alu_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .opcode      (opcode),
    .set_flags   (set_flags),
    .rn          (rn),
    .op2         (op2),
    .shift_carry (shift_carry),
    .flags_in    (flags_in),
    .res_valid   (res_valid),
    .result      (result),
    .result_we   (result_we),
    .flags_out   (flags_out)
);

// File: tb/sim_dp_alu_core.sv
`timescale 1ns/1ps
module sim_dp_alu_core;
    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;
    localparam int HALF = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   opcode = '0;
    logic         set_flags = 1'b0;
    logic [W-1:0] rn = '0;
    logic [W-1:0] op2 = '0;
    logic         shift_carry = 1'b0;
    logic [3:0]   flags_in = '0;
    logic         res_valid;
    logic [W-1:0] result;
    logic         result_we;
    logic [3:0]   flags_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dp_alu_core #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .set_flags(set_flags), .rn(rn), .op2(op2), .shift_carry(shift_carry),
        .flags_in(flags_in), .res_valid(res_valid), .result(result),
        .result_we(result_we), .flags_out(flags_out)
    );

    // expected values for the vector currently applied
    int   e_res;
    logic e_we;
    logic [3:0] e_fl;
    string e_req;

    function automatic int sgn(input int x);
        return (x >= HALF) ? x - (1 << W) : x;
    endfunction

    task automatic model(input int op, input int a, input int b, input int c,
                         input int sf, input int shc, input logic [3:0] fi);
        int u; int s; int arith; int upd; int cc; int vv;
        arith = 0; upd = sf; e_we = 1; u = 0; s = 0;
        case (op)
            4: begin u = a + b;         s = sgn(a) + sgn(b);         arith = 1; e_req = "R3"; end
            5: begin u = a + b + c;     s = sgn(a) + sgn(b) + c;     arith = 1; e_req = "R3"; end
            2: begin u = a - b;         s = sgn(a) - sgn(b);         arith = 1; e_req = "R4"; end
            6: begin u = a - b - (1-c); s = sgn(a) - sgn(b) - (1-c); arith = 1; e_req = "R4"; end
            3: begin u = b - a;         s = sgn(b) - sgn(a);         arith = 1; e_req = "R5"; end
            7: begin u = b - a - (1-c); s = sgn(b) - sgn(a) - (1-c); arith = 1; e_req = "R5"; end
            10: begin u = a - b; s = sgn(a) - sgn(b); arith = 1; upd = 1; e_we = 0; e_req = "R8"; end
            11: begin u = a + b; s = sgn(a) + sgn(b); arith = 1; upd = 1; e_we = 0; e_req = "R8"; end
            0:  begin u = a & b;          e_req = "R6"; end
            1:  begin u = a ^ b;          e_req = "R6"; end
            12: begin u = a | b;          e_req = "R6"; end
            14: begin u = a & (~b & MASK); e_req = "R6"; end
            13: begin u = b;              e_req = "R7"; end
            15: begin u = ~b & MASK;      e_req = "R7"; end
            default: begin e_we = 0; upd = 0; e_req = "R13"; end
        endcase
        // unsigned carry: no-borrow for subtract forms, overflow past MASK for add forms
        cc = (u < 0) ? 0 : ((u > MASK) ? 1 : 0);
        if (op == 2 || op == 6 || op == 3 || op == 7 || op == 10) cc = (u >= 0) ? 1 : 0;
        vv = (s < -HALF || s > HALF - 1) ? 1 : 0;
        e_res = u & MASK;
        if (!upd) begin
            e_fl = fi;
            if (op != 10 && op != 11 && op != 8 && op != 9) e_req = {e_req, "/R9"};
        end else if (arith) begin
            e_fl = {e_res[W-1], e_res == 0, cc[0], vv[0]};
            e_req = {e_req, "/R10/R11"};
        end else begin
            e_fl = {e_res[W-1], e_res == 0, shc[0], fi[0]};
            e_req = {e_req, "/R10/R12"};
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] keep_res;
        logic [3:0]   keep_fl;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {res_valid, result_we, result, flags_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {res_valid, result_we, result, flags_out}, 0);

        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a <= MASK; a++) begin
                for (int b = 0; b <= MASK; b++) begin
                    for (int m = 0; m < 4; m++) begin
                        int c; int sf; int shc; logic [3:0] fi;
                        c = m & 1; sf = m >> 1;
                        shc = (a ^ b ^ m) & 1;
                        fi = {a[0], b[1], c[0], (a[2] ^ b[0] ^ sf[0])};
                        opcode = op[3:0]; rn = a[W-1:0]; op2 = b[W-1:0];
                        set_flags = sf[0]; shift_carry = shc[0]; flags_in = fi;
                        op_valid = 1'b1;
                        model(op, a, b, c, sf, shc, fi);
                        @(negedge clk);
                        chk({e_req, " result"}, result, e_res);
                        chk({e_req, " we"}, result_we, e_we);
                        chk({e_req, " flags"}, flags_out, e_fl);
                        chk("R2 valid", res_valid, 1);
                    end
                end
            end
        end

        // R2: idle cycle holds the result and flags, drops valid and write enable
        keep_res = result; keep_fl = flags_out;
        op_valid = 1'b0; opcode = 4'd4; rn = 4'd3; op2 = 4'd9; flags_in = 4'hF;
        @(negedge clk);
        chk("R2 idle valid", res_valid, 0);
        chk("R2 idle we", result_we, 0);
        chk("R2 idle result", result, keep_res);
        chk("R2 idle flags", flags_out, keep_fl);

        // R7: rn swept under MOV with fixed op2 never changes result
        for (int a = 0; a <= MASK; a++) begin
            op_valid = 1'b1; opcode = 4'd13; rn = a[W-1:0]; op2 = 4'h6; set_flags = 1'b0;
            @(negedge clk);
            chk("R7 rn ignored", result, 6);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule